// File: doc/BRIEF.md
# Serial Flash Power-Mode Controller

This block keeps track of the power state of a serial NOR flash command front end. It observes the active-low chip select, a strobe that marks a fully decoded 8-bit instruction, and a busy flag from the internal program/erase engine. From these inputs it reports one of three modes: active, standby or deep sleep. It also drives an accept gate that tells the command decoder whether it may act on an instruction. A small write-enable latch sits inside the block, so the effect of the gate on a state-changing instruction can be seen at the ports.

An instruction counts only once the select line returns high after the opcode strobe. The sleep opcode then puts the part into deep sleep. In that state every instruction except the wake opcode is dropped with no effect. After a wake, a recovery window of a parameterised length blocks new instructions until the part is ready again. The serial bit shifting and the real program/erase timing belong to neighbouring blocks.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: A synchronous active-high reset sets mode to standby (00), raises `accept`, lowers `recovering` and clears `wel`. Mode encoding: 00 standby, 01 active, 10 deep sleep.
- R2: Outside deep sleep, a cycle in which `cs_n` is sampled low makes `mode` read active (01) at the next clock.
- R3: While `busy` is high, `mode` stays active even with `cs_n` high. It changes to standby at the first clock that samples both `busy` low and `cs_n` high.
- R4: Only the first `op_valid` strobe seen while `cs_n` is low is captured. It takes effect at the clock that first samples `cs_n` high. Strobes while deselected are ignored, and a selection with no strobe does nothing.
- R5: A committed sleep opcode B9h, taken while `accept` is high, sets `mode` to deep sleep (10) and lowers `accept` at the commit clock.
- R6: In deep sleep, neither `cs_n` low nor `busy` changes `mode`. Only a committed wake opcode ABh leaves deep sleep.
- R7: In deep sleep, any opcode other than ABh is dropped. A write-enable opcode 06h there leaves `wel` unchanged.
- R8: A wake commit sets `mode` from `cs_n`/`busy` and holds `recovering` high and `accept` low for exactly RECOVERY_CYCLES clocks. Opcodes committed in that window are dropped. `accept` returns high as `recovering` falls.
- R9: With `accept` high, a committed 06h sets `wel` and a committed 04h clears it.
- R10: A committed ABh outside deep sleep changes neither `mode` nor `accept` and starts no recovery window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| op_valid | input | 1 | Strobe marking a complete decoded opcode |
| opcode | input | OPW | Decoded opcode value |
| busy | input | 1 | Internal program/erase/status-write cycle running |
| mode | output | 2 | Power mode: 00 standby, 01 active, 10 deep sleep |
| accept | output | 1 | Decoder may act on instructions |
| recovering | output | 1 | Wake recovery window in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The hardest state to reach from the ports is an opcode committed inside the wake recovery window. `mode` has already left deep sleep there, yet the instruction must still be dropped. The stimulus sends the wake opcode and starts a full write-enable select at once. The commit lands a few clocks into an eight-clock window, and the bench checks that `wel` stays clear while `recovering` is still high. The test of the first-strobe rule sends two strobes in a single selection, ordered so that keeping the later opcode would give the opposite `wel` value.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    PM_STANDBY = 2'b00,
    PM_ACTIVE  = 2'b01,
    PM_DEEP    = 2'b10
  } pwr_mode_e;

  localparam int unsigned OPW_DEF = 8;
  localparam logic [7:0] OP_SLEEP_DEF = 8'hB9;
  localparam logic [7:0] OP_WAKE_DEF  = 8'hAB;
  localparam logic [7:0] OP_WREN_DEF  = 8'h06;
  localparam logic [7:0] OP_WRDI_DEF  = 8'h04;
endpackage

// File: rtl/fpc_op_capture.sv
module fpc_op_capture #(
  parameter int unsigned OPW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] opcode,
  output logic           commit,
  output logic [OPW-1:0] commit_op
);
  logic           cs_q;
  logic           pend_v;
  logic [OPW-1:0] pend_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b1;
      pend_v  <= 1'b0;
      pend_op <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        pend_v <= 1'b0;
      end else if (op_valid && !pend_v) begin
        pend_v  <= 1'b1;
        pend_op <= opcode;
      end
    end
  end

  // the instruction is acted on at the first clock after select closes
  assign commit    = cs_n && !cs_q && pend_v;
  assign commit_op = pend_op;

  // R4: the first opcode held in a selection is never replaced
  p_first_strobe_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !cs_n) |=> $stable(pend_op));
  // R4: a capture never survives into the next selection
  p_pending_dropped_r4: assert property (@(posedge clk) disable iff (rst)
    commit |=> !pend_v);
endmodule

// File: rtl/fpc_mode_fsm.sv
module fpc_mode_fsm
  import fpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cs_n,
  input  logic      busy,
  input  logic      enter_dp,
  input  logic      release_dp,
  output pwr_mode_e mode_q,
  output pwr_mode_e mode_d
);
  pwr_mode_e awake_mode;

  always_comb begin
    awake_mode = (!cs_n || busy) ? PM_ACTIVE : PM_STANDBY;
    if (mode_q == PM_DEEP) begin
      mode_d = release_dp ? awake_mode : PM_DEEP;
    end else if (enter_dp) begin
      mode_d = PM_DEEP;
    end else begin
      mode_d = awake_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= PM_STANDBY;
    else     mode_q <= mode_d;
  end

  // R2: selection forces active outside deep sleep
  p_select_active_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && mode_q != PM_DEEP && !enter_dp) |=> (mode_q == PM_ACTIVE));
  // R3: running internal cycle keeps the part active
  p_busy_active_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q != PM_DEEP && !enter_dp) |=> (mode_q == PM_ACTIVE));
  // R6: deep sleep is left only through the wake opcode
  p_deep_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_DEEP && !release_dp) |=> (mode_q == PM_DEEP));
  // R5: sleep commit lands in deep sleep
  p_sleep_enters_r5: assert property (@(posedge clk) disable iff (rst)
    enter_dp |=> (mode_q == PM_DEEP));
endmodule

// File: rtl/fpc_recovery_timer.sv
module fpc_recovery_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic rec_q,
  output logic rec_d
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (start) begin
      cnt_d = CW'(CYCLES);
      rec_d = 1'b1;
    end else begin
      cnt_d = (cnt_q != '0) ? cnt_q - CW'(1) : '0;
      rec_d = (cnt_q > CW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rec_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rec_q <= rec_d;
    end
  end

  // R8: window opens on the wake commit
  p_window_opens_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> rec_q);
  // R8: window closes when the count runs out
  p_window_closes_r8: assert property (@(posedge clk) disable iff (rst)
    (rec_q && cnt_q == CW'(1) && !start) |=> !rec_q);

  initial begin
    if (CYCLES < 1) $error("CYCLES must be at least 1");
  end
endmodule

// File: rtl/fpc_wel_latch.sv
module fpc_wel_latch #(
  parameter int unsigned   OPW     = 8,
  parameter logic [OPW-1:0] OP_SET = 8'h06,
  parameter logic [OPW-1:0] OP_CLR = 8'h04
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           commit,
  input  logic [OPW-1:0] commit_op,
  input  logic           gate,
  output logic           wel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q <= 1'b0;
    end else if (commit && gate) begin
      if (commit_op == OP_SET)      wel_q <= 1'b1;
      else if (commit_op == OP_CLR) wel_q <= 1'b0;
    end
  end

  // R7: a blocked instruction leaves the latch untouched
  p_latch_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !gate |=> $stable(wel_q));
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
  import fpc_pkg::*;
#(
  parameter int unsigned    OPW             = OPW_DEF,
  parameter int unsigned    RECOVERY_CYCLES = 8,
  parameter logic [OPW-1:0] OP_SLEEP        = OP_SLEEP_DEF,
  parameter logic [OPW-1:0] OP_WAKE         = OP_WAKE_DEF,
  parameter logic [OPW-1:0] OP_WREN         = OP_WREN_DEF,
  parameter logic [OPW-1:0] OP_WRDI         = OP_WRDI_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] opcode,
  input  logic           busy,
  output logic [1:0]     mode,
  output logic           accept,
  output logic           recovering,
  output logic           wel
);
  logic           commit;
  logic [OPW-1:0] commit_op;
  logic           enter_dp;
  logic           release_dp;
  logic           rec_q;
  logic           rec_d;
  logic           accept_q;
  pwr_mode_e      mode_q;
  pwr_mode_e      mode_d;

  fpc_op_capture #(.OPW(OPW)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .op_valid (op_valid),
    .opcode   (opcode),
    .commit   (commit),
    .commit_op(commit_op)
  );

  assign enter_dp   = commit && (commit_op == OP_SLEEP) && accept_q;
  assign release_dp = commit && (commit_op == OP_WAKE) && (mode_q == PM_DEEP);

  fpc_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .busy      (busy),
    .enter_dp  (enter_dp),
    .release_dp(release_dp),
    .mode_q    (mode_q),
    .mode_d    (mode_d)
  );

  fpc_recovery_timer #(.CYCLES(RECOVERY_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(release_dp),
    .rec_q(rec_q),
    .rec_d(rec_d)
  );

  fpc_wel_latch #(.OPW(OPW), .OP_SET(OP_WREN), .OP_CLR(OP_WRDI)) u_wel (
    .clk      (clk),
    .rst      (rst),
    .commit   (commit),
    .commit_op(commit_op),
    .gate     (accept_q),
    .wel_q    (wel)
  );

  always_ff @(posedge clk) begin
    if (rst) accept_q <= 1'b1;
    else     accept_q <= (mode_d != PM_DEEP) && !rec_d;
  end

  assign mode       = mode_q;
  assign accept     = accept_q;
  assign recovering = rec_q;

  // R5: no instruction is accepted in deep sleep
  p_deep_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PM_DEEP) |-> !accept_q);
  // R8: no instruction is accepted while recovering
  p_recover_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    rec_q |-> !accept_q);
  // R10: wake outside deep sleep starts no window
  p_wake_outside_r10: assert property (@(posedge clk) disable iff (rst)
    (commit && commit_op == OP_WAKE && mode_q != PM_DEEP && !rec_q) |=> !rec_q);
endmodule

// File: tb/test_flash_pwr_ctrl.sv
module test_flash_pwr_ctrl;
  localparam int REC = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic       busy = 1'b0;
  logic [1:0] mode;
  logic       accept;
  logic       recovering;
  logic       wel;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flash_pwr_ctrl #(.RECOVERY_CYCLES(REC)) i_flash_pwr_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .op_valid(op_valid), .opcode(opcode),
    .busy(busy), .mode(mode), .accept(accept), .recovering(recovering), .wel(wel)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    n_run++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // one complete selection carrying a single opcode; returns at the
  // negedge after the commit clock
  task automatic send_op(input logic [7:0] op);
    @(negedge clk); cs_n = 1'b0; op_valid = 1'b1; opcode = op;
    @(negedge clk); op_valid = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "mode", mode, 0);
    check("R1", "accept", accept, 1);
    check("R1", "recovering", recovering, 0);
    check("R1", "wel", wel, 0);
  endtask

  task automatic t_select;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); check("R2", "mode while selected", mode, 1);
    cs_n = 1'b1;
    @(negedge clk); check("R2", "mode after deselect", mode, 0);
  endtask

  task automatic t_busy;
    @(negedge clk); cs_n = 1'b0; busy = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); check("R3", "mode deselected busy", mode, 1);
    repeat (3) @(negedge clk);
    check("R3", "mode still busy", mode, 1);
    busy = 1'b0;
    @(negedge clk); check("R3", "mode after busy", mode, 0);
  endtask

  task automatic t_wel;
    send_op(8'h06); check("R9", "wel after 06h", wel, 1);
    send_op(8'h04); check("R9", "wel after 04h", wel, 0);
    send_op(8'h06); check("R9", "wel set again", wel, 1);
  endtask

  task automatic t_capture;
    // strobe while deselected is dropped
    @(negedge clk); op_valid = 1'b1; opcode = 8'h04;
    @(negedge clk); op_valid = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); check("R4", "wel after stray strobe", wel, 1);
    // first strobe wins within one selection
    @(negedge clk); cs_n = 1'b0; op_valid = 1'b1; opcode = 8'h04;
    @(negedge clk); opcode = 8'h06;
    @(negedge clk); op_valid = 1'b0;
    @(negedge clk); check("R4", "wel before select closes", wel, 1);
    cs_n = 1'b1;
    @(negedge clk); check("R4", "wel first strobe wins", wel, 0);
  endtask

  task automatic t_deep;
    send_op(8'hB9);
    check("R5", "mode after sleep", mode, 2);
    check("R5", "accept after sleep", accept, 0);
  endtask

  task automatic t_deep_ignore;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); check("R6", "mode selected in sleep", mode, 2);
    cs_n = 1'b1; busy = 1'b1;
    @(negedge clk); check("R6", "mode busy in sleep", mode, 2);
    busy = 1'b0;
    send_op(8'h06);
    check("R7", "wel after 06h in sleep", wel, 0);
    check("R7", "mode after 06h in sleep", mode, 2);
    send_op(8'hB9);
    check("R6", "mode after repeat sleep", mode, 2);
  endtask

  task automatic t_release;
    send_op(8'hAB);
    check("R8", "mode after wake", mode, 0);
    check("R8", "recovering after wake", recovering, 1);
    check("R8", "accept after wake", accept, 0);
    send_op(8'h06);  // commits four clocks into the window
    check("R8", "wel for 06h in window", wel, 0);
    check("R8", "recovering mid window", recovering, 1);
    repeat (3) @(negedge clk);
    check("R8", "recovering last cycle", recovering, 1);
    check("R8", "accept last cycle", accept, 0);
    @(negedge clk);
    check("R8", "recovering ended", recovering, 0);
    check("R8", "accept restored", accept, 1);
  endtask

  task automatic t_wake_outside;
    send_op(8'hAB);
    check("R10", "mode", mode, 0);
    check("R10", "recovering", recovering, 0);
    check("R10", "accept", accept, 1);
    send_op(8'h06);
    check("R9", "wel set after window", wel, 1);
  endtask

  initial begin
    t_reset;
    t_select;
    t_busy;
    t_wel;
    t_capture;
    t_deep;
    t_deep_ignore;
    t_release;
    t_wake_outside;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule